// File: doc/BRIEF.md
# Clock Output Mode Selector

This block sits between the frequency synthesizer of a clock generator and its output pads. It reads two strap pins once after reset, turns them into one of four operating modes and then drives four clock outputs: a CPU clock, a PCI clock, a free-running PCI clock and a reference clock. Each output comes with its own output-enable, so a pad driver outside the block can release the line.

In the two normal modes the synthesized clocks pass straight to the outputs. The straps pick whether the CPU output carries the 66.6 MHz or the 100 MHz source, and a speed flag reports the choice. In test mode every output is derived from an external test clock. The CPU output is the test clock divided by two, both PCI outputs are the test clock divided by six, and the reference output carries the test clock itself. In the float mode every enable is low. The synthesizer itself is outside the block: its clocks arrive as input signals.

Top module: `clksel_top`

## Requirements
- R1: Until the first rising edge of `clk` after `rst_n` is released, all four enables and all four clock outputs are low and `cpu_fast` is low.
- R2: The straps are sampled only at that first edge. Any later change on `strap_sel` or `strap_ts_n` has no effect on the enables, the clock outputs or `cpu_fast` until the next reset.
- R3: With straps `strap_sel`=0 and `strap_ts_n`=0 (float mode), all four enables stay low and all four clock outputs stay low, whatever the synthesized inputs do.
- R4: With `strap_sel`=0 and `strap_ts_n`=1, all enables are high, `cpu_clk` follows `syn_cpu66` and `cpu_fast` is 0.
- R5: With `strap_sel`=1 and `strap_ts_n`=1, all enables are high, `cpu_clk` follows `syn_cpu100` and `cpu_fast` is 1. `cpu_fast` is 1 in no other mode.
- R6: In both normal modes `pci_clk` and `pcif_clk` follow `syn_pci`, and `ref_clk` follows `syn_ref`.
- R7: With `strap_sel`=1 and `strap_ts_n`=0 (test mode), all enables are high and `cpu_clk` toggles on every rising edge of `tclk`, giving `tclk`/2 with a 50% duty cycle.
- R8: In test mode `pci_clk` and `pcif_clk` are `tclk`/6: each is high for 3 `tclk` periods, then low for 3, and the two are identical.
- R9: In test mode `ref_clk` equals `tclk`.
- R10: In test mode both dividers start from zero. Both outputs are low until the dividers start. The first rise of `pci_clk` comes exactly two `tclk` rising edges after the first rise of `cpu_clk`, and that first rise of `cpu_clk` falls within 6 `tclk` edges of the strap sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; samples the straps |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 1 | Mode strap, speed/test select |
| strap_ts_n | input | 1 | Mode strap, active-low float/test select |
| tclk | input | 1 | External test clock |
| syn_cpu66 | input | 1 | Synthesized 66.6 MHz CPU clock |
| syn_cpu100 | input | 1 | Synthesized 100 MHz CPU clock |
| syn_pci | input | 1 | Synthesized 33.3 MHz PCI clock |
| syn_ref | input | 1 | Reference clock from the crystal |
| cpu_clk | output | 1 | CPU clock output |
| cpu_oe | output | 1 | Enable for the CPU clock pad |
| pci_clk | output | 1 | PCI clock output |
| pci_oe | output | 1 | Enable for the PCI clock pad |
| pcif_clk | output | 1 | Free-running PCI clock output |
| pcif_oe | output | 1 | Enable for the free-running PCI clock pad |
| ref_clk | output | 1 | Reference clock output |
| ref_oe | output | 1 | Enable for the reference clock pad |
| cpu_fast | output | 1 | 1 when the CPU output carries the 100 MHz source |

## Verification
The hardest situation to reach from the ports is the start of the test dividers, because the mode is frozen at the first edge after reset and the dividers only start once the run request has crossed into the test clock domain. The bench therefore passes through reset once for every strap combination. In test mode it records every output across sixty cycles from the moment of release, then locates the first CPU rise and checks the divide pattern and the two-edge offset of the PCI rise against it. Strap changes are applied after capture in each mode to show that the mode cannot change on the fly.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  // Mode encoding is {strap_sel, strap_ts_n}.
  typedef enum logic [1:0] {
    MD_FLOAT   = 2'b00,
    MD_NORM66  = 2'b01,
    MD_TEST    = 2'b10,
    MD_NORM100 = 2'b11
  } mode_e;

  function automatic mode_e decode_straps(input logic sel, input logic ts_n);
    mode_e m;
    case ({sel, ts_n})
      2'b00:   m = MD_FLOAT;
      2'b01:   m = MD_NORM66;
      2'b10:   m = MD_TEST;
      default: m = MD_NORM100;
    endcase
    return m;
  endfunction

  // Half period of an even divider, in input clock edges.
  function automatic int unsigned half_period(input int unsigned div);
    return (div < 2) ? 1 : div / 2;
  endfunction

  function automatic logic drives_pads(input mode_e m);
    return m != MD_FLOAT;
  endfunction

endpackage

// File: rtl/clksel_strap.sv
module clksel_strap
  import clksel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  ts_n,
  output mode_e mode_q,
  output logic  captured_q,
  output logic  sample_ev
);

  // The straps are read on the first edge after reset and then held.
  assign sample_ev = ~captured_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_FLOAT;
      captured_q <= 1'b0;
    end else if (sample_ev) begin
      mode_q     <= decode_straps(sel, ts_n);
      captured_q <= 1'b1;
    end
  end

endmodule

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain_q;

  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[N-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[N-1];

endmodule

// File: rtl/clksel_div.sv
module clksel_div
  import clksel_pkg::*;
#(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic q,
  output logic flip_ev
);

  localparam int unsigned HALF = half_period(DIV);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic phase_q;

  generate
    if (HALF == 1) begin : g_toggle
      assign flip_ev = run;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign flip_ev = run && (cnt_q == CW'(HALF - 1));
      // The counter is held at zero while idle, so the phase is fixed at start.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (flip_ev) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (!run)    phase_q <= 1'b0;
    else if (flip_ev) phase_q <= ~phase_q;
  end

  assign q = phase_q;

endmodule

// File: rtl/clksel_outmux.sv
module clksel_outmux
  import clksel_pkg::*;
(
  input  mode_e mode,
  input  logic  captured,
  input  logic  tclk,
  input  logic  syn_cpu66,
  input  logic  syn_cpu100,
  input  logic  syn_pci,
  input  logic  syn_ref,
  input  logic  cpu_div,
  input  logic  pci_div,
  output logic  cpu_clk,
  output logic  pci_clk,
  output logic  pcif_clk,
  output logic  ref_clk,
  output logic  pads_on,
  output logic  cpu_fast
);

  assign pads_on  = captured && drives_pads(mode);
  assign cpu_fast = captured && (mode == MD_NORM100);

  always_comb begin
    cpu_clk  = 1'b0;
    pci_clk  = 1'b0;
    pcif_clk = 1'b0;
    ref_clk  = 1'b0;
    if (captured) begin
      case (mode)
        MD_NORM66: begin
          cpu_clk  = syn_cpu66;
          pci_clk  = syn_pci;
          pcif_clk = syn_pci;
          ref_clk  = syn_ref;
        end
        MD_NORM100: begin
          cpu_clk  = syn_cpu100;
          pci_clk  = syn_pci;
          pcif_clk = syn_pci;
          ref_clk  = syn_ref;
        end
        MD_TEST: begin
          cpu_clk  = cpu_div;
          pci_clk  = pci_div;
          pcif_clk = pci_div;
          ref_clk  = tclk;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int unsigned CPU_TEST_DIV = 2,
  parameter int unsigned PCI_TEST_DIV = 6,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_sel,
  input  logic strap_ts_n,
  input  logic tclk,
  input  logic syn_cpu66,
  input  logic syn_cpu100,
  input  logic syn_pci,
  input  logic syn_ref,
  output logic cpu_clk,
  output logic cpu_oe,
  output logic pci_clk,
  output logic pci_oe,
  output logic pcif_clk,
  output logic pcif_oe,
  output logic ref_clk,
  output logic ref_oe,
  output logic cpu_fast
);

  mode_e mode_q;
  logic  captured_q;
  logic  sample_ev;
  logic  test_req;
  logic  test_run_t;
  logic  cpu_div;
  logic  pci_div;
  logic  cpu_flip_ev;
  logic  pci_flip_ev;
  logic  pads_on;

  clksel_strap u_strap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (strap_sel),
    .ts_n       (strap_ts_n),
    .mode_q     (mode_q),
    .captured_q (captured_q),
    .sample_ev  (sample_ev)
  );

  assign test_req = captured_q && (mode_q == MD_TEST);

  clksel_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk   (tclk),
    .rst_n (rst_n),
    .d     (test_req),
    .q     (test_run_t)
  );

  clksel_div #(.DIV(CPU_TEST_DIV)) u_cpu_div (
    .clk     (tclk),
    .rst_n   (rst_n),
    .run     (test_run_t),
    .q       (cpu_div),
    .flip_ev (cpu_flip_ev)
  );

  clksel_div #(.DIV(PCI_TEST_DIV)) u_pci_div (
    .clk     (tclk),
    .rst_n   (rst_n),
    .run     (test_run_t),
    .q       (pci_div),
    .flip_ev (pci_flip_ev)
  );

  clksel_outmux u_mux (
    .mode       (mode_q),
    .captured   (captured_q),
    .tclk       (tclk),
    .syn_cpu66  (syn_cpu66),
    .syn_cpu100 (syn_cpu100),
    .syn_pci    (syn_pci),
    .syn_ref    (syn_ref),
    .cpu_div    (cpu_div),
    .pci_div    (pci_div),
    .cpu_clk    (cpu_clk),
    .pci_clk    (pci_clk),
    .pcif_clk   (pcif_clk),
    .ref_clk    (ref_clk),
    .pads_on    (pads_on),
    .cpu_fast   (cpu_fast)
  );

  assign cpu_oe  = pads_on;
  assign pci_oe  = pads_on;
  assign pcif_oe = pads_on;
  assign ref_oe  = pads_on;

endmodule

// File: rtl/clksel_top_chk.sv
module clksel_top_chk
  import clksel_pkg::*;
(
  input logic  clk,
  input logic  tclk,
  input logic  rst_n,
  input mode_e mode,
  input logic  captured,
  input logic  run_t,
  input logic  cpu_div,
  input logic  pci_div,
  input logic  cpu_oe,
  input logic  pci_oe,
  input logic  pcif_oe,
  input logic  ref_oe,
  input logic  cpu_fast
);

  // Length of the current PCI divider level, counted in test clock edges.
  logic       pci_prev_q;
  logic       pci_seen_q;
  logic [3:0] pci_same_q;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      pci_prev_q <= 1'b0;
      pci_seen_q <= 1'b0;
      pci_same_q <= '0;
    end else begin
      pci_prev_q <= pci_div;
      if (!run_t) begin
        pci_seen_q <= 1'b0;
        pci_same_q <= '0;
      end else if (pci_div != pci_prev_q) begin
        pci_seen_q <= 1'b1;
        pci_same_q <= '0;
      end else if (pci_same_q != 4'hf) begin
        pci_same_q <= pci_same_q + 1'b1;
      end
    end
  end

  p_quiet_before_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (!cpu_oe && !pci_oe && !pcif_oe && !ref_oe && !cpu_fast));

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> ($stable(mode) && captured));

  p_float_pads_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && mode == MD_FLOAT) |-> (!cpu_oe && !pci_oe && !pcif_oe && !ref_oe));

  p_fast_only_in_100_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fast |-> (captured && mode == MD_NORM100));

  p_cpu_toggles_r7: assert property (@(posedge tclk) disable iff (!rst_n)
    (run_t && $past(run_t)) |-> (cpu_div != $past(cpu_div)));

  p_pci_level_len_r8: assert property (@(posedge tclk) disable iff (!rst_n)
    (run_t && pci_seen_q) |-> (pci_same_q <= 4'd2));

  p_div_idle_low_r10: assert property (@(posedge tclk) disable iff (!rst_n)
    (!run_t && !$past(run_t)) |-> (!cpu_div && !pci_div));

endmodule

bind clksel_top clksel_top_chk u_chk (
  .clk      (clk),
  .tclk     (tclk),
  .rst_n    (rst_n),
  .mode     (mode_q),
  .captured (captured_q),
  .run_t    (test_run_t),
  .cpu_div  (cpu_div),
  .pci_div  (pci_div),
  .cpu_oe   (cpu_oe),
  .pci_oe   (pci_oe),
  .pcif_oe  (pcif_oe),
  .ref_oe   (ref_oe),
  .cpu_fast (cpu_fast)
);

// File: tb/clksel_top_test.sv
module clksel_top_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_sel = 1'b0;
  logic strap_ts_n = 1'b0;
  logic syn_cpu66 = 1'b0;
  logic syn_cpu100 = 1'b0;
  logic syn_pci = 1'b0;
  logic syn_ref = 1'b0;
  logic tclk;
  logic cpu_clk, cpu_oe, pci_clk, pci_oe, pcif_clk, pcif_oe, ref_clk, ref_oe, cpu_fast;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;
  assign tclk = clk;

  clksel_top uut (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .strap_ts_n(strap_ts_n),
    .tclk(tclk), .syn_cpu66(syn_cpu66), .syn_cpu100(syn_cpu100),
    .syn_pci(syn_pci), .syn_ref(syn_ref),
    .cpu_clk(cpu_clk), .cpu_oe(cpu_oe), .pci_clk(pci_clk), .pci_oe(pci_oe),
    .pcif_clk(pcif_clk), .pcif_oe(pcif_oe), .ref_clk(ref_clk), .ref_oe(ref_oe),
    .cpu_fast(cpu_fast)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] oes();
    return {cpu_oe, pci_oe, pcif_oe, ref_oe};
  endfunction

  function automatic logic [3:0] clks();
    return {cpu_clk, pci_clk, pcif_clk, ref_clk};
  endfunction

  // Reset with given straps; check the quiet window before the first sample edge.
  task automatic boot(input logic sel, input logic ts_n);
    @(negedge clk);
    rst_n = 1'b0;
    strap_sel = sel;
    strap_ts_n = ts_n;
    syn_cpu66 = 1'b1; syn_cpu100 = 1'b1; syn_pci = 1'b1; syn_ref = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 enables in reset", {4'b0, oes()}, 8'h00);
    chk("R1 clocks in reset", {3'b0, cpu_fast, clks()}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 enables before sample", {4'b0, oes()}, 8'h00);
    chk("R1 clocks before sample", {3'b0, cpu_fast, clks()}, 8'h00);
  endtask

  // Normal mode sweep over every combination of the synthesized inputs.
  task automatic sweep_normal(input logic fast);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {syn_cpu66, syn_cpu100, syn_pci, syn_ref} = 4'(v);
      #1;
      chk(fast ? "R5 enables" : "R4 enables", {4'b0, oes()}, 8'h0f);
      chk(fast ? "R5 speed flag" : "R4 speed flag", {7'b0, cpu_fast}, {7'b0, fast});
      chk(fast ? "R5 cpu source" : "R4 cpu source", {7'b0, cpu_clk},
          {7'b0, fast ? syn_cpu100 : syn_cpu66});
      chk("R6 pci pair", {6'b0, pci_clk, pcif_clk}, {6'b0, syn_pci, syn_pci});
      chk("R6 ref", {7'b0, ref_clk}, {7'b0, syn_ref});
    end
  endtask

  logic cpu_s [60];
  logic pci_s [60];
  logic pcif_s [60];

  initial begin
    // Mode 66: straps 0,1
    boot(1'b0, 1'b1);
    sweep_normal(1'b0);
    // R2: strap changes after sampling are ignored
    @(negedge clk);
    strap_sel = 1'b1; strap_ts_n = 1'b0;
    syn_cpu66 = 1'b1; syn_cpu100 = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 66 mode kept, enables", {4'b0, oes()}, 8'h0f);
    chk("R2 66 mode kept, flag", {7'b0, cpu_fast}, 8'h00);
    chk("R2 66 mode kept, cpu", {7'b0, cpu_clk}, 8'h01);

    // Mode 100: straps 1,1
    boot(1'b1, 1'b1);
    sweep_normal(1'b1);
    @(negedge clk);
    strap_sel = 1'b0; strap_ts_n = 1'b0;
    syn_cpu66 = 1'b0; syn_cpu100 = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 100 mode kept, enables", {4'b0, oes()}, 8'h0f);
    chk("R2 100 mode kept, cpu", {6'b0, cpu_fast, cpu_clk}, 8'h03);

    // Float mode: straps 0,0
    boot(1'b0, 1'b0);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {syn_cpu66, syn_cpu100, syn_pci, syn_ref} = 4'(v);
      #1;
      chk("R3 enables off", {4'b0, oes()}, 8'h00);
      chk("R3 clocks low", {3'b0, cpu_fast, clks()}, 8'h00);
    end
    @(negedge clk);
    strap_sel = 1'b1; strap_ts_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 float mode kept", {4'b0, oes()}, 8'h00);

    // Test mode: straps 1,0
    boot(1'b1, 1'b0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      #1;
      cpu_s[i] = cpu_clk;
      pci_s[i] = pci_clk;
      pcif_s[i] = pcif_clk;
      if (i > 0) begin
        chk("R7 test enables", {4'b0, oes()}, 8'h0f);
        chk("R7 test flag", {7'b0, cpu_fast}, 8'h00);
        chk("R9 ref low with tclk low", {7'b0, ref_clk}, 8'h00);
      end
    end
    // Test mode changes on straps must not matter either
    strap_sel = 1'b0; strap_ts_n = 1'b1;
    begin
      int k;
      k = -1;
      for (int i = 0; i < 60; i++) if (k < 0 && cpu_s[i]) k = i;
      chk("R10 cpu start window", {7'b0, (k >= 0 && k <= 6)}, 8'h01);
      if (k < 0) k = 0;
      for (int i = 0; i < k; i++)
        chk("R10 idle low", {6'b0, cpu_s[i], pci_s[i]}, 8'h00);
      for (int i = k; i < 50; i++)
        chk("R7 cpu is tclk/2", {7'b0, cpu_s[i]}, {7'b0, ((i - k) % 2) == 0});
      chk("R10 pci low before offset", {6'b0, pci_s[k], pci_s[k+1]}, 8'h00);
      for (int i = k + 2; i < 56; i++) begin
        chk("R8 pci is tclk/6", {7'b0, pci_s[i]}, {7'b0, ((i - k - 2) % 6) < 3});
        chk("R8 pcif equals pci", {7'b0, pcif_s[i]}, {7'b0, pci_s[i]});
      end
    end
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1;
      chk("R9 ref high with tclk high", {7'b0, ref_clk}, 8'h01);
      chk("R2 test mode kept", {4'b0, oes()}, 8'h0f);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule